// File: doc/BRIEF.md
# NAND Hamming Parity Generator

This block builds a single-error-correcting Hamming parity code over one 512-byte block of NAND data as the bytes pass on the flash data bus. Each valid strobe carries either one byte or one 16-bit word, depending on a column-width input. For every bit-index weight inside a byte (1, 2, 4) and every byte-address weight (8 up to 2048), the block keeps two parities. The "odd" parity covers the positions where that address bit is 1. The "even" parity covers the positions where it is 0.

Software or a controller state machine writes a control word with the clear bit set before each block. It then streams the block and, once the done flag rises, reads either the 32-bit result word or the packed 3-byte code. A larger page is handled as a run of 512-byte blocks, with a clear between blocks, and each block yields its own code. The code is not inverted. Data of all zeros therefore gives a zero code, and an erased block of all ones also gives a zero code rather than 0xFFFFFF.

Top module: `hecc_gen`

## Requirements
- R1: After reset, `result_o` and `code_o` are zero and `done_o` is low.
- R2: `result_o` bits 0 to 11 hold the even parities for weights 1, 2, 4, 8, ... 2048, lowest weight in bit 0.
- R3: `result_o` bits 16 to 27 hold the odd parities in the same weight order. Bits 12 to 15 and 28 to 31 always read zero.
- R4: The weight-1, 2 and 4 parities XOR every data bit whose bit index (0 to 7) inside its byte has that index bit set (odd) or clear (even).
- R5: The weight-8 to 2048 parities XOR the parity of every byte whose block address (0 to 511) has address bit 0 to 8 set (odd) or clear (even).
- R6: `code_o[7:0]` is result bits 7:0, `code_o[15:8]` is result bits 23:16, `code_o[19:16]` is result bits 11:8 and `code_o[23:20]` is result bits 27:24.
- R7: The code is not inverted: an all-zero block and an all-ones block both give `code_o` = 0.
- R8: With `wide_i` = 0, each strobe adds `data_i[7:0]` as the next byte address.
- R9: With `wide_i` = 1, each strobe adds `data_i[7:0]` at byte address 2n and `data_i[15:8]` at 2n+1.
- R10: A cycle with `ctl_we_i` = 1 and `ctl_i[8]` = 1 zeroes all parities and the byte count, and takes priority over a strobe in the same cycle. A write with bit 8 clear has no effect.
- R11: `done_o` rises in the cycle after the strobe that completes exactly 512 bytes, and not before.
- R12: While `done_o` is high, strobes are ignored and the result stays unchanged until the next clear.
- R13: A strobe changes `result_o` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_i | input | 16 | Control word; bit 8 requests a clear |
| stb_i | input | 1 | Data valid strobe |
| wide_i | input | 1 | Column width: 0 = 8-bit, 1 = 16-bit |
| data_i | input | 16 | Flash data bus |
| result_o | output | 32 | Even parities in bits 11:0, odd parities in bits 27:16 |
| code_o | output | 24 | Packed 3-byte code |
| done_o | output | 1 | Block complete; result frozen |

## Verification
A single flipped accumulator bit shows in `result_o` at the next check. The bench compares the result after every strobe, so a wrong parity update is caught at the byte that caused it, not only at the end of the block. A byte count that is off by one, or wrong in wide mode, moves the address-weighted parities and shifts the rise of `done_o` by a strobe. Both show within one strobe of the first wrong address. A freeze that leaks after done shows on the first extra strobe.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  // bit-index weights inside one byte
  localparam int COL_W    = 3;
  localparam int RES_W    = 32;
  localparam int ODD_BASE = 16;
  localparam int CODE_W   = 24;

  function automatic logic [CODE_W-1:0] pack_code(input logic [RES_W-1:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction
endpackage

// File: rtl/hecc_lane.sv
module hecc_lane #(
  parameter int LINE_W = 9,
  localparam int NP = hecc_pkg::COL_W + LINE_W
) (
  input  logic [7:0]        byte_i,
  input  logic [LINE_W-1:0] addr_i,
  input  logic              en_i,
  output logic [NP-1:0]     ev_o,
  output logic [NP-1:0]     od_o
);
  import hecc_pkg::*;

  logic [COL_W-1:0] col_ev, col_od;
  logic             row_par;

  assign row_par = ^byte_i;

  always_comb begin
    col_ev = '0;
    col_od = '0;
    for (int k = 0; k < COL_W; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> k) & 1) == 1) col_od[k] = col_od[k] ^ byte_i[b];
        else                     col_ev[k] = col_ev[k] ^ byte_i[b];
      end
    end
  end

  assign ev_o[COL_W-1:0] = en_i ? col_ev : '0;
  assign od_o[COL_W-1:0] = en_i ? col_od : '0;

  for (genvar k = 0; k < LINE_W; k++) begin : g_line
    assign ev_o[COL_W+k] = en_i & row_par & ~addr_i[k];
    assign od_o[COL_W+k] = en_i & row_par &  addr_i[k];
  end
endmodule

// File: rtl/hecc_count.sv
module hecc_count #(
  parameter int BLOCK_BYTES = 512,
  localparam int LINE_W = $clog2(BLOCK_BYTES),
  localparam int CNT_W  = LINE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic              wide_i,
  output logic [LINE_W-1:0] addr0_o,
  output logic [LINE_W-1:0] addr1_o,
  output logic              en0_o,
  output logic              en1_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] BLK = CNT_W'(BLOCK_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             done_q;

  assign en0_o   = stb_i & ~done_q & ~clr_i;
  assign en1_o   = en0_o & wide_i & ((cnt_q + CNT_W'(1)) < BLK);
  assign addr0_o = cnt_q[LINE_W-1:0];
  assign addr1_o = cnt_q[LINE_W-1:0] + LINE_W'(1);
  assign cnt_nx  = cnt_q + CNT_W'(en0_o) + CNT_W'(en1_o);
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      done_q <= (cnt_nx == BLK);
    end
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= BLK);

  // R11
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(en0_o));

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr_i) |=> done_q);
endmodule

// File: rtl/hecc_acc.sv
module hecc_acc #(
  parameter int NP    = 12,
  parameter int NLANE = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_i,
  input  logic                       any_en_i,
  input  logic [NLANE-1:0][NP-1:0]   ev_add_i,
  input  logic [NLANE-1:0][NP-1:0]   od_add_i,
  output logic [NP-1:0]              ev_o,
  output logic [NP-1:0]              od_o
);
  logic [NP-1:0] ev_q, od_q, ev_sum, od_sum;

  always_comb begin
    ev_sum = '0;
    od_sum = '0;
    for (int l = 0; l < NLANE; l++) begin
      ev_sum = ev_sum ^ ev_add_i[l];
      od_sum = od_sum ^ od_add_i[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      ev_q <= '0;
      od_q <= '0;
    end else begin
      ev_q <= ev_q ^ ev_sum;
      od_q <= od_q ^ od_sum;
    end
  end

  assign ev_o = ev_q;
  assign od_o = od_q;

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (ev_q == '0 && od_q == '0));

  // R12
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_en_i && !clr_i) |=> ($stable(ev_q) && $stable(od_q)));

  // R4 R5: every even/odd pair sums to the same total parity
  pair_sum_chk: assert property (@(posedge clk) disable iff (rst)
    ((ev_q ^ od_q) == '0) || ((ev_q ^ od_q) == '1));
endmodule

// File: rtl/hecc_gen.sv
module hecc_gen #(
  parameter int BLOCK_BYTES = 512,
  parameter int CTL_W       = 16,
  parameter int CLR_BIT     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we_i,
  input  logic [15:0] ctl_i,
  input  logic        stb_i,
  input  logic        wide_i,
  input  logic [15:0] data_i,
  output logic [31:0] result_o,
  output logic [23:0] code_o,
  output logic        done_o
);
  import hecc_pkg::*;

  localparam int LINE_W = $clog2(BLOCK_BYTES);
  localparam int NP     = COL_W + LINE_W;
  localparam int NLANE  = 2;

  logic                     clr;
  logic [NLANE-1:0]         lane_en;
  logic [LINE_W-1:0]        lane_addr [NLANE];
  logic [NLANE-1:0][NP-1:0] lane_ev, lane_od;
  logic [NP-1:0]            acc_ev, acc_od;

  assign clr = ctl_we_i & ctl_i[CLR_BIT];

  hecc_count #(.BLOCK_BYTES(BLOCK_BYTES)) u_count (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .stb_i   (stb_i),
    .wide_i  (wide_i),
    .addr0_o (lane_addr[0]),
    .addr1_o (lane_addr[1]),
    .en0_o   (lane_en[0]),
    .en1_o   (lane_en[1]),
    .done_o  (done_o)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    hecc_lane #(.LINE_W(LINE_W)) u_lane (
      .byte_i (data_i[8*l +: 8]),
      .addr_i (lane_addr[l]),
      .en_i   (lane_en[l]),
      .ev_o   (lane_ev[l]),
      .od_o   (lane_od[l])
    );
  end

  hecc_acc #(.NP(NP), .NLANE(NLANE)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .any_en_i (|lane_en),
    .ev_add_i (lane_ev),
    .od_add_i (lane_od),
    .ev_o     (acc_ev),
    .od_o     (acc_od)
  );

  always_comb begin
    result_o = '0;
    result_o[NP-1:0]             = acc_ev;
    result_o[ODD_BASE +: NP]     = acc_od;
  end

  assign code_o = pack_code(result_o);

  // R3
  spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (result_o[15:12] == 4'h0) && (result_o[31:28] == 4'h0));
endmodule

// File: tb/hecc_gen_test.sv
module hecc_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl = '0;
  logic        stb = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] data = '0;
  logic [31:0] result;
  logic [23:0] code;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [11:0] m_ev, m_od;
  int          m_cnt;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  hecc_gen uut (
    .clk(clk), .rst(rst), .ctl_we_i(ctl_we), .ctl_i(ctl),
    .stb_i(stb), .wide_i(wide), .data_i(data),
    .result_o(result), .code_o(code), .done_o(done)
  );

  function automatic logic [31:0] exp_res();
    return {4'h0, m_od, 4'h0, m_ev};
  endfunction

  function automatic logic [23:0] exp_code();
    logic [31:0] r = exp_res();
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ev = '0; m_od = '0; m_cnt = 0;
  endtask

  // R4 R5: arithmetic parity contribution of one byte at address a
  task automatic model_byte(input logic [7:0] v, input int a);
    for (int b = 0; b < 8; b++)
      if (v[b])
        for (int k = 0; k < 3; k++)
          if (((b >> k) & 1) == 1) m_od[k] = ~m_od[k]; else m_ev[k] = ~m_ev[k];
    if (^v)
      for (int k = 0; k < 9; k++)
        if (((a >> k) & 1) == 1) m_od[3+k] = ~m_od[3+k]; else m_ev[3+k] = ~m_ev[3+k];
  endtask

  task automatic do_clear();
    @(negedge clk); ctl_we = 1'b1; ctl = 16'h0100;
    @(negedge clk); ctl_we = 1'b0; ctl = '0;
    model_reset();
  endtask

  task automatic strobe(input logic w, input logic [15:0] d);
    @(negedge clk); stb = 1'b1; wide = w; data = d;
    if (m_cnt < 512) begin
      model_byte(d[7:0], m_cnt); m_cnt++;
      if (w && m_cnt < 512) begin model_byte(d[15:8], m_cnt); m_cnt++; end
    end
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic check_all(input string tag);
    check(tag, result, exp_res());
    check("R6", {8'h0, code}, {8'h0, exp_code()});
    check("R11", {31'h0, done}, {31'h0, (m_cnt == 512)});
  endtask

  function automatic logic [15:0] pattern(input int kind, input int i);
    case (kind)
      0: return lf;
      1: return 16'h0000;
      2: return 16'hFFFF;
      default: return {8'h1 << ((i + 3) % 8), 8'h1 << (i % 8)};
    endcase
  endfunction

  task automatic run_block(input logic w, input int kind, input string tag);
    int n;
    do_clear();
    n = w ? 256 : 512;
    for (int i = 0; i < n; i++) begin
      strobe(w, pattern(kind, i));
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      check_all(tag);
    end
  endtask

  initial begin
    logic [31:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, 32'h0);
    check("R1", {8'h0, code}, 32'h0);
    check("R1", {31'h0, done}, 32'h0);

    run_block(1'b0, 0, "R8");
    check("R3", {result[31:28], result[15:12]}, 8'h0);
    check("R11", {31'h0, done}, 32'h1);

    held = result;
    for (int i = 0; i < 5; i++) begin
      strobe(i[0], 16'h5A3C + 16'(i));
      check("R12", result, held);
      check("R12", {31'h0, done}, 32'h1);
    end

    // R10: write without the clear bit
    @(negedge clk); ctl_we = 1'b1; ctl = 16'hFEFF;
    @(negedge clk); ctl_we = 1'b0; ctl = '0;
    check("R10", result, held);
    check("R10", {31'h0, done}, 32'h1);

    // R10: clear together with a strobe
    @(negedge clk); ctl_we = 1'b1; ctl = 16'h0100; stb = 1'b1; data = 16'h00FE;
    @(negedge clk); ctl_we = 1'b0; ctl = '0; stb = 1'b0;
    model_reset();
    check("R10", result, 32'h0);
    check("R10", {31'h0, done}, 32'h0);

    run_block(1'b1, 0, "R9");

    run_block(1'b0, 1, "R7");
    check("R7", {8'h0, code}, 32'h0);
    run_block(1'b1, 2, "R7");
    check("R7", {8'h0, code}, 32'h0);

    run_block(1'b0, 3, "R4");
    run_block(1'b1, 3, "R5");
    check("R2", {20'h0, result[11:0]}, {20'h0, m_ev});

    // R13: one-edge latency
    do_clear();
    @(negedge clk); stb = 1'b1; wide = 1'b0; data = 16'h0080;
    #1;
    check("R13", result, 32'h0);
    model_byte(8'h80, 0); m_cnt = 1;
    @(negedge clk); stb = 1'b0;
    check("R13", result, exp_res());

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule